// File: doc/BRIEF.md
# Round-Robin Interrupt Pending Selector

This block chooses which internal interrupt source a CPU should service next. It takes a bank of 32 or 64 sources and serves up to two CPUs. Each CPU has its own enable-mask words and its own raw status words. Each CPU also keeps its own resume pointer, so no source is ever favoured over another by a fixed order. When a CPU pulses its dispatch strobe, the block forms that CPU's pending set as status AND mask. It then searches upward from the CPU's pointer, wrapping at the source count, and takes the first pending index it finds. One cycle later the block reports that index and moves the pointer one place past it.

Software changes the enables through one operation port. A mask operation disables a source on every CPU. An unmask operation enables the source only on CPUs that are online and that fall inside an optional affinity set. On every other CPU the unmask clears the bit. The mask words are held in reversed word order, so the word with the higher source numbers sits at the lower word address. A read port exposes each stored word. A fixed window of source indices can be flagged as cascaded external lines. When cascading is on, a chosen source inside that window is reported with an external flag and an index rebased to the window start.

Top module: `rr_irq_sel`

## Requirements
- R1: After reset every mask bit of every CPU is 0, both resume pointers are 0 and no result is valid.
- R2: The pending set of a CPU is its status word AND its mask word, bit by bit. A source whose mask bit is 0 is never reported, even when its status bit is 1.
- R3: A dispatch reports the first pending source at or after the CPU's pointer, searching upward. With every source pending, successive dispatches report 0, 1, 2, and so on.
- R4: If nothing is pending for the requesting CPU, res_valid_o stays 0, res_ext_o and res_id_o read 0, and that CPU's pointer is unchanged.
- R5: After a hit on source n, the pointer equals (n+1) modulo NUM_SRC. A hit on the last source is therefore followed by a search that starts at source 0.
- R6: Each CPU has its own pointer and its own mask. A dispatch by one CPU does not move the other CPU's pointer.
- R7: When cascade_en_i is 1 and the chosen index n satisfies EXT_START <= n <= EXT_END, res_ext_o is 1 and res_id_o is n-EXT_START. Otherwise res_ext_o is 0 and res_id_o is n. The defaults are 8 and 11.
- R8: A mask operation (op_valid_i=1, op_unmask_i=0) clears the enable bit of op_src_i for every CPU.
- R9: An unmask operation sets the enable bit of op_src_i for CPU c when cpu_online_i[c] is 1 and either op_aff_valid_i is 0 or op_aff_i[c] is 1. For every other CPU it clears the bit.
- R10: In the 64-source configuration, source n is stored in word (n/32) XOR 1 at bit n mod 32. Word 0 therefore holds sources 32..63 and word 1 holds sources 0..31. mask_rd_data_o returns the word chosen by mask_rd_cpu_i and mask_rd_word_i.
- R11: The result of a strobe appears in the cycle after the strobe. A strobe held for consecutive cycles is served once per cycle, in order. A mask operation in the same cycle as a dispatch does not affect that dispatch.
- R12: Both CPUs may dispatch in the same cycle, and each receives its own independent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_online_i | input | NUM_CPU | Online flag per CPU, used by unmask |
| cascade_en_i | input | 1 | Enables remapping of the external window |
| status_i | input | NUM_CPU*NUM_SRC | Raw status per CPU, in stored (word-reversed) layout |
| disp_i | input | NUM_CPU | Dispatch strobe per CPU |
| op_valid_i | input | 1 | Mask or unmask operation strobe |
| op_unmask_i | input | 1 | 1 selects unmask, 0 selects mask |
| op_src_i | input | IDX_W | Source index of the operation |
| op_aff_valid_i | input | 1 | An affinity set is supplied with the unmask |
| op_aff_i | input | NUM_CPU | Affinity set |
| mask_rd_cpu_i | input | CPU_W | CPU selected for mask read |
| mask_rd_word_i | input | WSEL_W | Stored word selected for mask read |
| mask_rd_data_o | output | 32 | Selected mask word |
| res_valid_o | output | NUM_CPU | A source was chosen for the CPU |
| res_ext_o | output | NUM_CPU | The chosen source lies in the cascaded window |
| res_id_o | output | NUM_CPU*IDX_W | Chosen source, rebased when external |

## Verification
The checker tests several rules on every cycle:
- a result never appears without a strobe in the cycle before;
- after each hit, the pointer holds the hit index plus one;
- a pointer never moves without a strobe, and it stays put after a strobe that finds nothing;
- an external result always lies inside the rebased window;
- a mask operation leaves the bit clear on every CPU.

Other behaviours can be shown only by the bench's scenarios against its own model:
- the search order and its wrap;
- the reversed word layout;
- the affinity and online rules on unmask;
- independence between the CPUs;
- the same-cycle write ordering;
- a long random mix of operations and dispatches.

// File: rtl/rr_irq_pkg.sv
package rr_irq_pkg;
  localparam int unsigned WORD_W = 32;

  // stored word index of a source: higher source words live at lower addresses
  function automatic int unsigned phys_word(int unsigned src, int unsigned n_words);
    return (src / WORD_W) ^ (n_words - 1);
  endfunction
endpackage

// File: rtl/rr_irq_mask_bank.sv
module rr_irq_mask_bank
  import rr_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned NUM_CPU = 2,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC),
  localparam int unsigned NW     = NUM_SRC / WORD_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_CPU-1:0]                cpu_online_i,
  input  logic                              op_valid_i,
  input  logic                              op_unmask_i,
  input  logic [IDX_W-1:0]                  op_src_i,
  input  logic                              op_aff_valid_i,
  input  logic [NUM_CPU-1:0]                op_aff_i,
  output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_phys_o
);
  logic [IDX_W-1:0] pos;

  always_comb begin
    pos = IDX_W'(phys_word(32'(op_src_i), NW) * WORD_W + (32'(op_src_i) % WORD_W));
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic en;
    logic [NUM_SRC-1:0] mask_q;

    assign en = cpu_online_i[c] & (~op_aff_valid_i | op_aff_i[c]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q <= '0;
      end else if (op_valid_i) begin
        mask_q[pos] <= op_unmask_i & en;
      end
    end

    assign mask_phys_o[c] = mask_q;
  end
endmodule

// File: rtl/rr_irq_pick.sv
module rr_irq_pick #(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               disp_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [IDX_W-1:0]   ptr_o
);
  logic [2*NUM_SRC-1:0] dbl;
  logic [NUM_SRC-1:0]   rot;
  logic                 found;
  logic [IDX_W-1:0]     off, sel;
  logic [IDX_W-1:0]     ptr_q, idx_q;
  logic                 hit_q;

  assign dbl = {pend_i, pend_i};
  assign rot = NUM_SRC'(dbl >> ptr_q);

  // lowest set bit of the rotated vector = first pending at or after ptr
  always_comb begin
    found = 1'b0;
    off   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (rot[i]) begin
        found = 1'b1;
        off   = IDX_W'(i);
      end
    end
    sel = ptr_q + off;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      idx_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= disp_i & found;
      if (disp_i && found) begin
        idx_q <= sel;
        ptr_q <= sel + IDX_W'(1);
      end
    end
  end

  assign hit_o = hit_q;
  assign idx_o = idx_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/rr_irq_remap.sv
module rr_irq_remap #(
  parameter int unsigned IDX_W     = 6,
  parameter int unsigned EXT_START = 8,
  parameter int unsigned EXT_END   = 11
) (
  input  logic             cascade_en_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             ext_o,
  output logic [IDX_W-1:0] id_o
);
  logic in_win;

  assign in_win = (32'(idx_i) >= EXT_START) && (32'(idx_i) <= EXT_END);
  assign ext_o  = hit_i & cascade_en_i & in_win;

  always_comb begin
    if (!hit_i)     id_o = '0;
    else if (ext_o) id_o = idx_i - IDX_W'(EXT_START);
    else            id_o = idx_i;
  end
endmodule

// File: rtl/rr_irq_sel.sv
module rr_irq_sel
  import rr_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_CPU   = 2,
  parameter int unsigned EXT_START = 8,
  parameter int unsigned EXT_END   = 11,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC),
  localparam int unsigned NW       = NUM_SRC / WORD_W,
  localparam int unsigned CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int unsigned WSEL_W   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_CPU-1:0]                cpu_online_i,
  input  logic                              cascade_en_i,
  input  logic [NUM_CPU-1:0][NUM_SRC-1:0]   status_i,
  input  logic [NUM_CPU-1:0]                disp_i,
  input  logic                              op_valid_i,
  input  logic                              op_unmask_i,
  input  logic [IDX_W-1:0]                  op_src_i,
  input  logic                              op_aff_valid_i,
  input  logic [NUM_CPU-1:0]                op_aff_i,
  input  logic [CPU_W-1:0]                  mask_rd_cpu_i,
  input  logic [WSEL_W-1:0]                 mask_rd_word_i,
  output logic [WORD_W-1:0]                 mask_rd_data_o,
  output logic [NUM_CPU-1:0]                res_valid_o,
  output logic [NUM_CPU-1:0]                res_ext_o,
  output logic [NUM_CPU-1:0][IDX_W-1:0]     res_id_o
);
  logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_phys_w, mask_log_w, stat_log_w;
  logic [NUM_CPU-1:0][IDX_W-1:0]   ptr_w, raw_w;

  rr_irq_mask_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_bank (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cpu_online_i   (cpu_online_i),
    .op_valid_i     (op_valid_i),
    .op_unmask_i    (op_unmask_i),
    .op_src_i       (op_src_i),
    .op_aff_valid_i (op_aff_valid_i),
    .op_aff_i       (op_aff_i),
    .mask_phys_o    (mask_phys_w)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar w = 0; w < NW; w++) begin : g_word
      localparam int unsigned PW = w ^ (NW - 1);
      assign mask_log_w[c][w*WORD_W +: WORD_W] = mask_phys_w[c][PW*WORD_W +: WORD_W];
      assign stat_log_w[c][w*WORD_W +: WORD_W] = status_i[c][PW*WORD_W +: WORD_W];
    end

    rr_irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .disp_i (disp_i[c]),
      .pend_i (stat_log_w[c] & mask_log_w[c]),
      .hit_o  (res_valid_o[c]),
      .idx_o  (raw_w[c]),
      .ptr_o  (ptr_w[c])
    );

    rr_irq_remap #(.IDX_W(IDX_W), .EXT_START(EXT_START), .EXT_END(EXT_END)) u_remap (
      .cascade_en_i (cascade_en_i),
      .hit_i        (res_valid_o[c]),
      .idx_i        (raw_w[c]),
      .ext_o        (res_ext_o[c]),
      .id_o         (res_id_o[c])
    );
  end

  always_comb begin
    mask_rd_data_o = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int w = 0; w < NW; w++) begin
        if (CPU_W'(c) == mask_rd_cpu_i && WSEL_W'(w) == mask_rd_word_i)
          mask_rd_data_o = mask_phys_w[c][w*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/rr_irq_sel_chk.sv
module rr_irq_sel_chk #(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned NUM_CPU   = 2,
  parameter int unsigned EXT_START = 8,
  parameter int unsigned EXT_END   = 11,
  localparam int unsigned IDX_W    = $clog2(NUM_SRC)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [NUM_CPU-1:0]              disp_i,
  input logic                            op_valid_i,
  input logic                            op_unmask_i,
  input logic [IDX_W-1:0]                op_src_i,
  input logic [NUM_CPU-1:0]              res_valid_o,
  input logic [NUM_CPU-1:0]              res_ext_o,
  input logic [NUM_CPU-1:0][IDX_W-1:0]   res_id_o,
  input logic [NUM_CPU-1:0][IDX_W-1:0]   ptr_w,
  input logic [NUM_CPU-1:0][IDX_W-1:0]   raw_w,
  input logic [NUM_CPU-1:0][NUM_SRC-1:0] mask_log_w
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    assert_result_after_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o[c] |-> $past(disp_i[c]));

    assert_ptr_past_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_valid_o[c] |-> (ptr_w[c] == raw_w[c] + IDX_W'(1)));

    assert_ptr_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !disp_i[c] |=> $stable(ptr_w[c]));

    assert_ptr_hold_on_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_i[c] |=> (res_valid_o[c] || $stable(ptr_w[c])));

    assert_ext_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_ext_o[c] |-> (res_valid_o[c] && (32'(res_id_o[c]) <= EXT_END - EXT_START)));

    assert_mask_clears_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_valid_i && !op_unmask_i) |=> !mask_log_w[c][$past(op_src_i)]);
  end
endmodule

bind rr_irq_sel rr_irq_sel_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .EXT_START(EXT_START), .EXT_END(EXT_END)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .disp_i      (disp_i),
  .op_valid_i  (op_valid_i),
  .op_unmask_i (op_unmask_i),
  .op_src_i    (op_src_i),
  .res_valid_o (res_valid_o),
  .res_ext_o   (res_ext_o),
  .res_id_o    (res_id_o),
  .ptr_w       (ptr_w),
  .raw_w       (raw_w),
  .mask_log_w  (mask_log_w)
);

// File: tb/rr_irq_sel_tb.sv
`timescale 1ns/1ps
module rr_irq_sel_tb;
  localparam int NS = 64;
  localparam int NC = 2;
  localparam int ES = 8;
  localparam int EE = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC-1:0] cpu_online_i = 2'b11;
  logic cascade_en_i = 1'b0;
  logic [NC-1:0][NS-1:0] status_i = '0;
  logic [NC-1:0] disp_i = '0;
  logic op_valid_i = 1'b0, op_unmask_i = 1'b0, op_aff_valid_i = 1'b0;
  logic [5:0] op_src_i = '0;
  logic [NC-1:0] op_aff_i = '0;
  logic [0:0] mask_rd_cpu_i = '0;
  logic [0:0] mask_rd_word_i = '0;
  logic [31:0] mask_rd_data_o;
  logic [NC-1:0] res_valid_o, res_ext_o;
  logic [NC-1:0][5:0] res_id_o;

  int n_chk = 0, n_err = 0;
  logic [63:0] mask_m [NC];
  int ptr_m [NC];

  always #2.5 clk = ~clk;

  rr_irq_sel u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_online_i(cpu_online_i), .cascade_en_i(cascade_en_i),
    .status_i(status_i), .disp_i(disp_i), .op_valid_i(op_valid_i), .op_unmask_i(op_unmask_i),
    .op_src_i(op_src_i), .op_aff_valid_i(op_aff_valid_i), .op_aff_i(op_aff_i),
    .mask_rd_cpu_i(mask_rd_cpu_i), .mask_rd_word_i(mask_rd_word_i), .mask_rd_data_o(mask_rd_data_o),
    .res_valid_o(res_valid_o), .res_ext_o(res_ext_o), .res_id_o(res_id_o)
  );

  function automatic logic [63:0] to_phys(logic [63:0] v);
    return {v[31:0], v[63:32]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic do_op(logic unm, int src, logic affv, logic [1:0] aff);
    @(negedge clk);
    op_valid_i = 1'b1; op_unmask_i = unm; op_src_i = 6'(src);
    op_aff_valid_i = affv; op_aff_i = aff;
    @(negedge clk);
    op_valid_i = 1'b0;
    for (int c = 0; c < NC; c++)
      mask_m[c][src] = unm && cpu_online_i[c] && (!affv || aff[c]);
  endtask

  // model result for cpu c; must be called before the model mask changes
  task automatic check_res(int c, logic [63:0] st, string tag);
    logic [63:0] p;
    int hit;
    logic ev, ee;
    logic [5:0] eid;
    p = st & mask_m[c];
    hit = -1;
    for (int k = 0; k < NS; k++) begin
      int n = (ptr_m[c] + k) % NS;
      if (hit < 0 && p[n]) hit = n;
    end
    ev = hit >= 0;
    if (ev) ptr_m[c] = (hit + 1) % NS;
    ee = ev && cascade_en_i && hit >= ES && hit <= EE;
    eid = !ev ? 6'd0 : (ee ? 6'(hit - ES) : 6'(hit));
    chk($sformatf("%s cpu%0d", tag, c), {61'd0, res_valid_o[c], res_ext_o[c], 1'b0} | 64'(res_id_o[c]) << 8,
        {61'd0, ev, ee, 1'b0} | 64'(eid) << 8);
  endtask

  task automatic dispatch(logic [1:0] cm, logic [63:0] st0, logic [63:0] st1, string tag);
    @(negedge clk);
    status_i[0] = to_phys(st0); status_i[1] = to_phys(st1); disp_i = cm;
    @(negedge clk);
    disp_i = '0;
    if (cm[0]) check_res(0, st0, tag);
    if (cm[1]) check_res(1, st1, tag);
  endtask

  task automatic rd(int c, int w, logic [31:0] exp, string tag);
    mask_rd_cpu_i = 1'(c); mask_rd_word_i = 1'(w);
    #0.1;
    chk(tag, 64'(mask_rd_data_o), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin mask_m[c] = '0; ptr_m[c] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid after reset", 64'(res_valid_o), 0);
    for (int c = 0; c < NC; c++) for (int w = 0; w < 2; w++) rd(c, w, 32'h0, "R1 mask after reset");
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 all status set but nothing enabled
    dispatch(2'b01, '1, '1, "R2 masked status ignored");
    // enable all sources on both CPUs
    for (int s = 0; s < NS; s++) do_op(1'b1, s, 1'b0, 2'b00);
    rd(0, 0, 32'hffff_ffff, "R9 unmask all");
    // R3 full sweep, R5 wrap
    for (int i = 0; i < NS; i++) dispatch(2'b01, '1, '1, "R3 sweep order");
    dispatch(2'b01, '1, '1, "R5 wrap to zero");
    // R6 cpu1 pointer untouched
    dispatch(2'b10, '1, '1, "R6 independent pointer");
    // R12 simultaneous
    dispatch(2'b11, '1, '1, "R12 simultaneous");
    dispatch(2'b11, 64'h0000_0000_0000_0100, 64'h8000_0000_0000_0000, "R12 distinct patterns");

    // R8 / R10 layout
    do_op(1'b0, 0, 1'b0, 2'b00);
    do_op(1'b0, 40, 1'b0, 2'b00);
    rd(0, 1, 32'hffff_fffe, "R10 word1 holds low sources");
    rd(0, 0, 32'hffff_feff, "R10 word0 holds high sources");
    rd(1, 1, 32'hffff_fffe, "R8 mask on cpu1");
    rd(1, 0, 32'hffff_feff, "R8 mask on cpu1 high");
    dispatch(2'b11, 64'h1, 64'h1, "R8 masked source not reported");

    // R9 affinity and online
    do_op(1'b1, 0, 1'b1, 2'b10);
    rd(0, 1, 32'hffff_fffe, "R9 affinity excludes cpu0");
    rd(1, 1, 32'hffff_ffff, "R9 affinity includes cpu1");
    cpu_online_i = 2'b01;
    do_op(1'b1, 40, 1'b0, 2'b00);
    rd(0, 0, 32'hffff_ffff, "R9 online cpu0 set");
    rd(1, 0, 32'hffff_feff, "R9 offline cpu1 cleared");
    do_op(1'b1, 5, 1'b0, 2'b00);
    rd(1, 1, 32'hffff_ffdf, "R9 offline unmask clears");
    cpu_online_i = 2'b11;
    do_op(1'b1, 5, 1'b0, 2'b00);

    // R7 cascade window
    cascade_en_i = 1'b1;
    dispatch(2'b01, 64'h200, 64'h0, "R7 inside window");
    dispatch(2'b01, 64'h100, 64'h0, "R7 window start");
    dispatch(2'b01, 64'h800, 64'h0, "R7 window end");
    dispatch(2'b01, 64'h1000, 64'h0, "R7 above window");
    dispatch(2'b01, 64'h80, 64'h0, "R7 below window");
    cascade_en_i = 1'b0;
    dispatch(2'b01, 64'h200, 64'h0, "R7 cascade off");

    // R4 miss keeps pointer
    dispatch(2'b01, 64'h0, 64'h0, "R4 nothing pending");
    dispatch(2'b01, '1, '1, "R4 resume after miss");

    // R11 back-to-back strobes
    @(negedge clk);
    status_i[0] = '1; disp_i = 2'b01;
    @(negedge clk);
    check_res(0, '1, "R11 first of pair");
    @(negedge clk);
    disp_i = '0;
    check_res(0, '1, "R11 second of pair");
    // R11 mask in same cycle as dispatch
    @(negedge clk);
    status_i[0] = to_phys(64'h20); disp_i = 2'b01;
    op_valid_i = 1'b1; op_unmask_i = 1'b0; op_src_i = 6'd5; op_aff_valid_i = 1'b0;
    @(negedge clk);
    disp_i = '0; op_valid_i = 1'b0;
    check_res(0, 64'h20, "R11 same-cycle mask not seen");
    mask_m[0][5] = 1'b0; mask_m[1][5] = 1'b0;
    dispatch(2'b01, 64'h20, 64'h0, "R11 mask seen next");

    // R3 random mix against model
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom % 4);
      if (r == 0) begin
        cpu_online_i = 2'($urandom | 1);
        do_op(1'($urandom), int'($urandom % NS), 1'($urandom), 2'($urandom));
        cpu_online_i = 2'b11;
      end else begin
        logic [63:0] a, b;
        a = {$urandom, $urandom} & {$urandom, $urandom};
        b = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        cascade_en_i = 1'($urandom);
        dispatch(2'($urandom | 1), a, b, "R3 random mix");
      end
    end
    finish_run();
  end
endmodule